// File: doc/BRIEF.md
# SPI Serial Memory Read Engine

This block is the serial front end of an 8 KiB byte-wide memory. It watches a mode-0 SPI bus (clock idles low) and a low-active chip select, oversampling both with the system clock. It collects an 8-bit command, most significant bit first. A memory-read command takes a 16-bit address, keeps only the low 13 bits, and streams bytes from a synchronous memory read port. It does this for as long as the host keeps clocking, moving to the next address after each byte and wrapping at the top of the space. A status-read command streams the byte presented by the status register unit. A write-enable command produces a one-cycle strobe toward that unit, but only when chip select rises right after the eighth command bit.

Write-type commands belong to a separate controller on the same pins, so this engine ignores them. It also ignores unknown commands until the next deselect. While chip select is high the serial output is disabled and all sequencing state returns to its idle values. The host clock must stay high for at least four system clocks and low for at least four system clocks. This gives the memory port time to return the next byte before the data is needed.

Top module: `spi_rd_engine`

## Requirements
- R1: Serial input is taken on rising SCK edges and serial output changes only on falling SCK edges. Every byte travels most significant bit first in both directions.
- R2: Command 0x03, then 16 address bits, starts a memory read. Only the low 13 address bits are used. The byte at that address appears on the first falling edge after the last address bit.
- R3: Each later byte of a read comes from the previous address plus one. The engine issues one single-cycle memory read pulse per loaded byte, plus one for the start of the read.
- R4: The read address wraps from 0x1FFF to 0x0000, and streaming continues without a break.
- R5: While chip select is high, the output enable is low and any command in progress is dropped. The next selection decodes a fresh command. After reset the output enable, the write-enable strobe and the memory read pulse are all low.
- R6: Command 0x05 streams the status input. It is captured again at the start of every output byte.
- R7: Command 0x06 followed directly by chip select rising gives exactly one single-cycle write-enable strobe, issued after the deselect.
- R8: If any further rising SCK edge arrives after command 0x06 while still selected, no write-enable strobe is produced.
- R9: Any other command (including 0x01 and 0x02) leaves the output disabled. It produces no memory read and no strobe for the rest of that selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the serial data pin |
| mem_rd_en | output | 1 | Single-cycle read request to the memory |
| mem_addr | output | 13 | Memory read address |
| mem_rd_data | input | 8 | Memory data, valid one cycle after a request |
| status_in | input | 8 | Current status byte |
| wr_latch_set | output | 1 | Single-cycle strobe that sets the write-enable latch |

## Verification
The bench reads across the top of the address space with junk in the three unused address bits. A design that kept those bits, or that failed to wrap, would return the wrong bytes after 0x1FFF. It sends the write-enable command both cleanly and with one or more trailing clocks. A design that fired on the opcode alone would strobe in the second case. It aborts reads in the middle of the address and in the middle of a data byte, then issues new commands. Counters that survive a deselect would misframe the following command. It also changes the status input between output bytes, and a design that captured status only once would repeat stale values.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_WR_STATUS = 8'h01;
    localparam logic [OPC_W-1:0] OPC_WR_ARRAY  = 8'h02;
    localparam logic [OPC_W-1:0] OPC_RD_ARRAY  = 8'h03;
    localparam logic [OPC_W-1:0] OPC_RD_STATUS = 8'h05;
    localparam logic [OPC_W-1:0] OPC_WR_ENABLE = 8'h06;

    typedef enum logic [2:0] {
        PH_OPC  = 3'd0,
        PH_ADDR = 3'd1,
        PH_DATA = 3'd2,
        PH_STAT = 3'd3,
        PH_ARM  = 3'd4,
        PH_SKIP = 3'd5
    } phase_e;

endpackage

// File: rtl/srd_sck_edge.sv
module srd_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise,
    output logic fall
);

    logic sck_d, sck_q;

    always_comb begin
        sck_d = sck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_d;
    end

    assign rise = sck & ~sck_q;
    assign fall = ~sck & sck_q;

endmodule

// File: rtl/srd_tx_shift.sv
module srd_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] val,
    output logic         so
);

    typedef struct packed {
        logic         bit_out;
        logic [W-2:0] rest;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (clr) begin
            tx_d = '0;
        end else if (load) begin
            {tx_d.bit_out, tx_d.rest} = val;
        end else if (shift) begin
            {tx_d.bit_out, tx_d.rest} = {tx_q.rest, 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign so = tx_q.bit_out;

endmodule

// File: rtl/spi_rd_engine.sv
module spi_rd_engine
    import spi_rd_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int ADDR_FIELD_W = 16,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic [DATA_W-1:0] status_in,
    output logic              wr_latch_set
);

    localparam int SHIFT_MAX = (ADDR_FIELD_W > OPC_W) ? ADDR_FIELD_W : OPC_W;
    localparam int CNT_W     = $clog2(SHIFT_MAX);
    localparam int OUT_W     = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  in_cnt;
        logic [OUT_W-1:0]  out_cnt;
        logic [OPC_W-1:0]  opc;
        logic [ADDR_W-1:0] addr;
        logic              rd_en;
        logic              pend;
        logic [DATA_W-1:0] nxt_byte;
        logic              oe;
        logic              wl;
    } eng_t;

    eng_t eng_d, eng_q;

    logic              sck_rise, sck_fall;
    logic              tx_load, tx_shift;
    logic [DATA_W-1:0] tx_val;
    logic [OPC_W-1:0]  opc_next;
    logic              byte_start;

    srd_sck_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.rd_en = 1'b0;
        eng_d.wl    = 1'b0;
        eng_d.pend  = eng_q.rd_en;
        if (eng_q.pend) eng_d.nxt_byte = mem_rd_data;

        tx_load    = 1'b0;
        tx_shift   = 1'b0;
        tx_val     = eng_q.nxt_byte;
        opc_next   = {eng_q.opc[OPC_W-2:0], si};
        byte_start = (eng_q.out_cnt == '0);

        if (cs_n) begin
            eng_d.ph      = PH_OPC;
            eng_d.in_cnt  = '0;
            eng_d.out_cnt = '0;
            eng_d.opc     = '0;
            eng_d.oe      = 1'b0;
            eng_d.wl      = (eng_q.ph == PH_ARM);
        end else begin
            unique case (eng_q.ph)
                PH_OPC: begin
                    if (sck_rise) begin
                        eng_d.opc = opc_next;
                        if (eng_q.in_cnt == CNT_W'(OPC_W - 1)) begin
                            eng_d.in_cnt = '0;
                            case (opc_next)
                                OPC_RD_ARRAY:  eng_d.ph = PH_ADDR;
                                OPC_RD_STATUS: eng_d.ph = PH_STAT;
                                OPC_WR_ENABLE: eng_d.ph = PH_ARM;
                                default:       eng_d.ph = PH_SKIP;
                            endcase
                        end else begin
                            eng_d.in_cnt = eng_q.in_cnt + 1'b1;
                        end
                    end
                end
                PH_ADDR: begin
                    if (sck_rise) begin
                        eng_d.addr = {eng_q.addr[ADDR_W-2:0], si};
                        if (eng_q.in_cnt == CNT_W'(ADDR_FIELD_W - 1)) begin
                            eng_d.in_cnt = '0;
                            eng_d.ph     = PH_DATA;
                            eng_d.rd_en  = 1'b1;
                        end else begin
                            eng_d.in_cnt = eng_q.in_cnt + 1'b1;
                        end
                    end
                end
                PH_DATA, PH_STAT: begin
                    if (sck_fall) begin
                        eng_d.oe = 1'b1;
                        if (eng_q.out_cnt == OUT_W'(DATA_W - 1)) eng_d.out_cnt = '0;
                        else                                     eng_d.out_cnt = eng_q.out_cnt + 1'b1;
                        if (byte_start) begin
                            tx_load = 1'b1;
                            if (eng_q.ph == PH_DATA) begin
                                tx_val      = eng_q.nxt_byte;
                                eng_d.addr  = eng_q.addr + 1'b1;
                                eng_d.rd_en = 1'b1;
                            end else begin
                                tx_val = status_in;
                            end
                        end else begin
                            tx_shift = 1'b1;
                        end
                    end
                end
                PH_ARM: begin
                    if (sck_rise) eng_d.ph = PH_SKIP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    srd_tx_shift #(.W(DATA_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cs_n),
        .load  (tx_load),
        .shift (tx_shift),
        .val   (tx_val),
        .so    (so)
    );

    assign so_oe        = eng_q.oe;
    assign mem_rd_en    = eng_q.rd_en;
    assign mem_addr     = eng_q.addr;
    assign wr_latch_set = eng_q.wl;

endmodule

// File: rtl/spi_rd_engine_chk.sv
module spi_rd_engine_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              cs_n,
    input logic              so,
    input logic              so_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              wr_latch_set
);

    p_oe_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_oe);

    p_oe_needs_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> !$past(cs_n));

    p_strobe_after_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch_set |-> $past(cs_n));

    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch_set |=> !wr_latch_set);

    p_so_moves_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && (so != $past(so))) |-> (!$past(sck) && $past(sck, 2)));

    p_addr_steps_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && (mem_addr != $past(mem_addr)))
            |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

bind spi_rd_engine spi_rd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/spi_rd_engine_tb_top.sv
module spi_rd_engine_tb_top;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        so, so_oe, mem_rd_en, wr_latch_set;
    logic [12:0] mem_addr;
    logic [7:0]  mem_rd_data = 8'h00;
    logic [7:0]  status_in = 8'h00;

    int total = 0;
    int bad = 0;
    int wl_cnt = 0;
    int rd_cnt = 0;
    logic oe_seen = 1'b0;

    always #2 clk = ~clk;

    spi_rd_engine dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck          (sck),
        .cs_n         (cs_n),
        .si           (si),
        .so           (so),
        .so_oe        (so_oe),
        .mem_rd_en    (mem_rd_en),
        .mem_addr     (mem_addr),
        .mem_rd_data  (mem_rd_data),
        .status_in    (status_in),
        .wr_latch_set (wr_latch_set)
    );

    function automatic logic [7:0] mem_val(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101} ^ 8'h3C;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_val(mem_addr);
        if (mem_rd_en) rd_cnt <= rd_cnt + 1;
        if (wr_latch_set) wl_cnt <= wl_cnt + 1;
        if (so_oe) oe_seen <= 1'b1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bit_x(input logic mosi, output logic miso);
        sck = 1'b0;
        si  = mosi;
        repeat (HALF) @(negedge clk);
        miso = so;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_x(tx[i], b);
            rx[i] = b;
        end
    endtask

    task automatic sel();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic desel();
        sck = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5", "output enable after deselect", int'(so_oe), 0);
    endtask

    task automatic do_read(input logic [15:0] a, input int n);
        logic [7:0]  rx;
        logic [12:0] exp_a;
        int r0;
        r0 = rd_cnt;
        sel();
        byte_x(8'h03, rx);
        byte_x(a[15:8], rx);
        byte_x(a[7:0], rx);
        for (int k = 0; k < n; k++) begin
            exp_a = 13'(a[12:0] + 13'(k));
            byte_x(8'h00, rx);
            if (k == 0)
                chk("R2 R1", "first read byte", int'(rx), int'(mem_val(exp_a)));
            else if (exp_a < a[12:0])
                chk("R4", "byte after wrap", int'(rx), int'(mem_val(exp_a)));
            else
                chk("R3", "next read byte", int'(rx), int'(mem_val(exp_a)));
        end
        desel();
        chk("R3", "memory read pulses", rd_cnt - r0, n + 2);
    endtask

    task automatic do_status(input int n);
        logic [7:0] rx;
        logic [7:0] sv;
        sel();
        byte_x(8'h05, rx);
        for (int k = 0; k < n; k++) begin
            sv = 8'($urandom);
            status_in = sv;
            byte_x(8'h00, rx);
            chk("R6", "status byte", int'(rx), int'(sv));
        end
        desel();
    endtask

    task automatic do_arm(input int extra);
        logic [7:0] rx;
        logic b;
        int w0;
        w0 = wl_cnt;
        sel();
        byte_x(8'h06, rx);
        for (int k = 0; k < extra; k++) bit_x(1'($urandom), b);
        desel();
        if (extra == 0) chk("R7", "strobe count", wl_cnt - w0, 1);
        else            chk("R8", "strobe count after extra clocks", wl_cnt - w0, 0);
    endtask

    task automatic do_other(input logic [7:0] op, input int nbytes);
        logic [7:0] rx;
        int w0, r0;
        w0 = wl_cnt;
        r0 = rd_cnt;
        oe_seen = 1'b0;
        sel();
        byte_x(op, rx);
        for (int k = 0; k < nbytes; k++) byte_x(8'($urandom), rx);
        desel();
        chk("R9", "output enable seen", int'(oe_seen), 0);
        chk("R9", "memory reads", rd_cnt - r0, 0);
        chk("R9", "strobes", wl_cnt - w0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        logic b;
        logic [7:0] op;
        int kind;
        void'($urandom(32'd20250611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5", "reset output enable", int'(so_oe), 0);
        chk("R5", "reset strobe", int'(wr_latch_set), 0);
        chk("R5", "reset memory pulse", int'(mem_rd_en), 0);

        do_read(16'h0000, 3);
        do_read(16'hE123, 2);
        do_read(16'hFFFE, 4);
        do_read(16'h1FFF, 2);
        do_status(3);
        do_arm(0);
        do_arm(1);
        do_arm(9);
        do_other(8'h02, 3);
        do_other(8'h01, 1);
        do_other(8'hA5, 2);

        sel();
        byte_x(8'h03, rx);
        bit_x(1'b1, b);
        bit_x(1'b0, b);
        bit_x(1'b1, b);
        desel();
        do_status(1);

        sel();
        byte_x(8'h03, rx);
        byte_x(8'h00, rx);
        byte_x(8'h40, rx);
        byte_x(8'h00, rx);
        bit_x(1'b0, b);
        bit_x(1'b0, b);
        desel();
        do_read(16'h0777, 1);

        for (int t = 0; t < 40; t++) begin
            kind = int'($urandom % 4);
            case (kind)
                0: do_read(16'($urandom), 1 + int'($urandom % 4));
                1: do_status(1 + int'($urandom % 3));
                2: do_arm(($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 8));
                default: begin
                    op = 8'($urandom);
                    if (op == 8'h03 || op == 8'h05 || op == 8'h06) op = 8'h02;
                    do_other(op, int'($urandom % 3));
                end
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule